// File: doc/BRIEF.md
# Microwire Sequential Read Front End

This block is the serial slave side of a 256-word by 16-bit memory on a Microwire-style bus with chip select (`cs`), serial clock (`sck`), serial data in (`din`) and serial data out (`dout`). All bus pins are sampled by the system clock `clk`, and a rising edge of `sck` is detected from the registered samples. After chip select rises while `sck` is low, the block waits for a start bit. It then shifts in a 2-bit opcode and an 8-bit address and decides what to do with the command.

A plain read streams words from an internal array model. The address pointer advances after each word for as long as chip select stays high, and it wraps from the top word to word zero. A read with the protect-enable pin (`pre_en`) high returns the protect register supplied by a sibling controller, followed by that controller's flag bit. Every other opcode is handed to the sibling controller through a one-cycle pulse together with the opcode and the address. Write handling, protection policy and programming timing sit in that sibling.

The controller is a single state machine with these states: `ST_IDLE` (chip select low), `ST_LOCKOUT` (chip select rose while `sck` was high), `ST_WAIT_START`, `ST_OPCODE`, `ST_ADDR`, `ST_STREAM` (array read), `ST_PREG` (protect register read) and `ST_DRAIN` (command done or forwarded). The transitions are:
- IDLE→WAIT_START when chip select rises with `sck` low.
- IDLE→LOCKOUT when chip select rises with `sck` high.
- WAIT_START→OPCODE on a start bit.
- OPCODE→ADDR after two opcode bits.
- ADDR→STREAM, ADDR→PREG or ADDR→DRAIN on the last address bit, according to the decoded command.
- PREG→DRAIN after the flag bit.
- Any state→IDLE whenever chip select is low.

Top module: `mw_seq_read`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `dout_oe` and `dout` are 0, `cmd_other` is 0 and the block is waiting for chip select.
- R2: A transaction starts only when chip select rises while `sck` is low. If chip select rises while `sck` is high, all bus activity is ignored (`dout` stays 0 and no command is forwarded) until chip select falls.
- R3: The first `din` value sampled as 1 on a rising `sck` is the start bit. Zeros sampled before it are ignored.
- R4: After the start bit, the next 2 rising `sck` edges shift in the opcode and the next 8 shift in the address, both most significant bit first.
- R5: Opcode 2'b10 with `pre_en` low at the last address bit is an array read. On that same rising edge `dout` becomes a dummy 0. Each of the following 16 rising edges presents one bit of the addressed word, most significant bit first. `dout` changes only after a rising `sck`, two `clk` cycles later.
- R6: While chip select stays high, the next word (address + 1) follows the last bit of a word directly, with no dummy bit.
- R7: The read pointer wraps from address 8'hFF to 8'h00.
- R8: Opcode 2'b10 with `pre_en` high at the last address bit is a protect register read. It outputs a dummy 0, then `prot_reg` most significant bit first, then `prot_flag`, all captured at the last address bit. After that `dout` stays 0.
- R9: Opcodes 2'b00, 2'b01 and 2'b11 produce a one-`clk` pulse on `cmd_other`, with `cmd_op` and `cmd_addr` holding the received opcode and address. `dout` stays 0 for the rest of the transaction.
- R10: `dout_oe` is high exactly while chip select is high, one `clk` after the pin. Chip select low aborts any transaction and forces `dout` to 0, and the next transaction starts again from the start bit.
- R11: The array word at address `a` is `{a, a} ^ 16'h5A3C`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the bus master |
| din | input | 1 | Serial data in |
| pre_en | input | 1 | Protect-enable pin, selects the protect register read |
| prot_reg | input | 8 | Protect register value from the sibling controller |
| prot_flag | input | 1 | Protect flag from the sibling controller |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout`; low models high impedance |
| cmd_other | output | 1 | One-cycle pulse for a forwarded command |
| cmd_op | output | 2 | Opcode of the forwarded command |
| cmd_addr | output | 8 | Address of the forwarded command |

## Verification
The bench reads words whose halves are not mirror images of each other, so a reversed or shifted address or bit order shows up as a wrong word. It streams across a word boundary and across the top address. A design that inserts a second dummy bit, skips a word or saturates at 8'hFF returns a misaligned or wrong second word. A transaction is also opened with `sck` high: a design without the lockout rule would decode the following bits and forward a command. The tests drop chip select in the middle of a stream and also send leading zeros before the start bit; a design that keeps stale count state would lose the dummy bit on the next read. Protect register reads are checked with both flag values, and the output is checked to stay low after the flag bit.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

    localparam int MW_ADDR_W = 8;
    localparam int MW_DATA_W = 16;
    localparam int MW_OP_W   = 2;
    localparam logic [1:0] MW_OP_READ = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCKOUT,
        ST_WAIT_START,
        ST_OPCODE,
        ST_ADDR,
        ST_STREAM,
        ST_PREG,
        ST_DRAIN
    } mw_state_e;

    typedef enum logic [1:0] {
        MW_CMD_READ,
        MW_CMD_PREG,
        MW_CMD_FWD
    } mw_cmd_e;

endpackage

// File: rtl/mw_input_sync.sv
module mw_input_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic din,
    input  logic pre_en,
    output logic cs_q,
    output logic sck_q,
    output logic din_q,
    output logic pre_q,
    output logic sck_rise,
    output logic cs_rise
);

    logic sck_prev;
    logic cs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b0;
            sck_q    <= 1'b0;
            din_q    <= 1'b0;
            pre_q    <= 1'b0;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b0;
        end else begin
            cs_q     <= cs;
            sck_q    <= sck;
            din_q    <= din;
            pre_q    <= pre_en;
            sck_prev <= sck_q;
            cs_prev  <= cs_q;
        end
    end

    assign sck_rise = sck_q & ~sck_prev;
    assign cs_rise  = cs_q & ~cs_prev;

    // R4: a serial clock edge is seen as one event, never two in a row
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
    import mw_rd_pkg::*;
#(
    parameter int OP_W = MW_OP_W
) (
    input  logic [OP_W-1:0] op,
    input  logic            pre,
    output mw_cmd_e         cmd
);

    always_comb begin
        if (op == OP_W'(MW_OP_READ)) begin
            cmd = pre ? MW_CMD_PREG : MW_CMD_READ;
        end else begin
            cmd = MW_CMD_FWD;
        end
    end

endmodule

// File: rtl/mw_word_rom.sv
module mw_word_rom #(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] SEED = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] tbl [DEPTH];

    // array model: each word is its address repeated, scrambled by SEED (R11)
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [ADDR_W-1:0] A = ADDR_W'(g);
        assign tbl[g] = DATA_W'({A, A}) ^ SEED;
    end

    assign word = tbl[addr];

endmodule

// File: rtl/mw_seq_read.sv
module mw_seq_read
    import mw_rd_pkg::*;
#(
    parameter int                ADDR_W = MW_ADDR_W,
    parameter int                DATA_W = MW_DATA_W,
    parameter int                OP_W   = MW_OP_W,
    parameter logic [DATA_W-1:0] SEED   = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sck,
    input  logic              din,
    input  logic              pre_en,
    input  logic [ADDR_W-1:0] prot_reg,
    input  logic              prot_flag,
    output logic              dout,
    output logic              dout_oe,
    output logic              cmd_other,
    output logic [OP_W-1:0]   cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam int PREG_W  = ADDR_W + 1;
    localparam int CNT_MAX = (DATA_W > PREG_W) ? DATA_W : PREG_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] PREG_LAST = CNT_W'(PREG_W - 1);

    logic cs_q, sck_q, din_q, pre_q, sck_rise, cs_rise;

    mw_state_e         state, nxt;
    mw_cmd_e           cmd;
    logic [CNT_W-1:0]  cnt;
    logic [OP_W-1:0]   op_sr;
    logic [ADDR_W-1:0] addr_sr;
    logic [ADDR_W-1:0] addr_full;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] word_sr;
    logic [PREG_W-1:0] preg_sr;
    logic              last_addr_bit;

    mw_input_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .sck      (sck),
        .din      (din),
        .pre_en   (pre_en),
        .cs_q     (cs_q),
        .sck_q    (sck_q),
        .din_q    (din_q),
        .pre_q    (pre_q),
        .sck_rise (sck_rise),
        .cs_rise  (cs_rise)
    );

    mw_cmd_decode #(.OP_W(OP_W)) u_dec (
        .op  (op_sr),
        .pre (pre_q),
        .cmd (cmd)
    );

    mw_word_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    // address as it stands once the current data-in bit is shifted in
    assign addr_full     = {addr_sr[ADDR_W-2:0], din_q};
    assign last_addr_bit = (state == ST_ADDR) && sck_rise && (cnt == ADDR_LAST);
    // decode time fetches the first word, streaming prefetches the next one
    assign rom_addr      = (state == ST_ADDR) ? addr_full : ptr + ADDR_W'(1);
    assign dout_oe       = cs_q;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!cs_q) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_rise) begin
                        nxt = sck_q ? ST_LOCKOUT : ST_WAIT_START;
                    end
                end
                ST_LOCKOUT: nxt = ST_LOCKOUT;
                ST_WAIT_START: begin
                    if (sck_rise && din_q) begin
                        nxt = ST_OPCODE;
                    end
                end
                ST_OPCODE: begin
                    if (sck_rise && (cnt == OP_LAST)) begin
                        nxt = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (last_addr_bit) begin
                        unique case (cmd)
                            MW_CMD_READ: nxt = ST_STREAM;
                            MW_CMD_PREG: nxt = ST_PREG;
                            default:     nxt = ST_DRAIN;
                        endcase
                    end
                end
                ST_STREAM: nxt = ST_STREAM;
                ST_PREG: begin
                    if (sck_rise && (cnt == PREG_LAST)) begin
                        nxt = ST_DRAIN;
                    end
                end
                ST_DRAIN: nxt = ST_DRAIN;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            op_sr     <= '0;
            addr_sr   <= '0;
            ptr       <= '0;
            word_sr   <= '0;
            preg_sr   <= '0;
            dout      <= 1'b0;
            cmd_other <= 1'b0;
            cmd_op    <= '0;
            cmd_addr  <= '0;
        end else begin
            cmd_other <= 1'b0;
            if (!cs_q) begin
                dout <= 1'b0;
                cnt  <= '0;
            end else begin
                unique case (state)
                    ST_WAIT_START: begin
                        cnt <= '0;
                    end
                    ST_OPCODE: begin
                        if (sck_rise) begin
                            op_sr <= {op_sr[OP_W-2:0], din_q};
                            cnt   <= (cnt == OP_LAST) ? '0 : cnt + CNT_W'(1);
                        end
                    end
                    ST_ADDR: begin
                        if (sck_rise) begin
                            addr_sr <= addr_full;
                            cnt     <= cnt + CNT_W'(1);
                            if (cnt == ADDR_LAST) begin
                                cnt     <= '0;
                                dout    <= 1'b0;
                                ptr     <= addr_full;
                                word_sr <= rom_word;
                                preg_sr <= {prot_reg, prot_flag};
                                if (cmd == MW_CMD_FWD) begin
                                    cmd_other <= 1'b1;
                                    cmd_op    <= op_sr;
                                    cmd_addr  <= addr_full;
                                end
                            end
                        end
                    end
                    ST_STREAM: begin
                        if (sck_rise) begin
                            dout <= word_sr[DATA_W-1];
                            if (cnt == WORD_LAST) begin
                                cnt     <= '0;
                                ptr     <= ptr + ADDR_W'(1);
                                word_sr <= rom_word;
                            end else begin
                                cnt     <= cnt + CNT_W'(1);
                                word_sr <= {word_sr[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_PREG: begin
                        if (sck_rise) begin
                            dout    <= preg_sr[PREG_W-1];
                            preg_sr <= {preg_sr[PREG_W-2:0], 1'b0};
                            cnt     <= cnt + CNT_W'(1);
                        end
                    end
                    ST_DRAIN: begin
                        if (sck_rise) begin
                            dout <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: chip select low returns the machine to idle with the output low
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_q |=> (state == ST_IDLE) && !dout);

    // R5: the bit after decoding a read is the dummy zero
    p_dummy_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_addr_bit && cs_q && (cmd != MW_CMD_FWD)) |=> !dout);

    // R5: with chip select high the output moves only after a serial clock rise
    p_hold_between_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && !sck_rise) |=> $stable(dout));

    // R7: the pointer wraps from the top word to zero
    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && (state == ST_STREAM) && sck_rise && (cnt == WORD_LAST)
         && (ptr == {ADDR_W{1'b1}})) |=> (ptr == '0));

    // R9: a forwarded command is a single-cycle pulse
    p_fwd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_other |=> !cmd_other);

    // R2: a locked-out transaction stays silent
    p_lockout_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKOUT) |-> (!dout && !cmd_other));

endmodule

// File: tb/tb_mw_seq_read.sv
module tb_mw_seq_read;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       sck = 1'b0;
    logic       din = 1'b0;
    logic       pre_en = 1'b0;
    logic [7:0] prot_reg = 8'h00;
    logic       prot_flag = 1'b0;
    logic       dout;
    logic       dout_oe;
    logic       cmd_other;
    logic [1:0] cmd_op;
    logic [7:0] cmd_addr;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    logic [1:0] last_op = 2'b00;
    logic [7:0] last_addr = 8'h00;

    always #10 clk = ~clk;

    mw_seq_read dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sck       (sck),
        .din       (din),
        .pre_en    (pre_en),
        .prot_reg  (prot_reg),
        .prot_flag (prot_flag),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .cmd_other (cmd_other),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr)
    );

    always @(posedge clk) begin
        if (cmd_other) begin
            n_pulse   <= n_pulse + 1;
            last_op   <= cmd_op;
            last_addr <= cmd_addr;
        end
    end

    function automatic logic [15:0] exp_word(input logic [7:0] a);
        return {a, a} ^ 16'h5A3C;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one serial bit: q is the output produced by this rising edge
    task automatic sbit(input logic d, output logic q);
        din = d;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        q = dout;
        sck = 1'b0;
    endtask

    task automatic cs_up();
        sck = 1'b0;
        cs = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_down();
        cs = 1'b0;
        din = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hdr(input logic [1:0] op, input logic [7:0] a, output logic q);
        logic t;
        sbit(1'b1, t);
        sbit(op[1], t);
        sbit(op[0], t);
        q = 1'b0;
        for (int i = 7; i >= 0; i--) sbit(a[i], q);
    endtask

    task automatic read16(output logic [15:0] w);
        logic b;
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b0, b);
            w[i] = b;
        end
    endtask

    task automatic t_reset();
        chk("R1", "dout_oe after reset", dout_oe, 0);
        chk("R1", "dout after reset", dout, 0);
        chk("R1", "no forwarded pulse", n_pulse, 0);
    endtask

    task automatic t_single_read();
        logic q;
        logic [15:0] w;
        pre_en = 1'b0;
        cs_up();
        chk("R10", "dout_oe with cs high", dout_oe, 1);
        hdr(2'b10, 8'h12, q);
        chk("R5", "dummy bit", q, 0);
        read16(w);
        chk("R11", "word at 12", w, exp_word(8'h12));
        cs_down();
        chk("R10", "dout_oe with cs low", dout_oe, 0);
        chk("R10", "dout low with cs low", dout, 0);
    endtask

    task automatic t_seq_read();
        logic q;
        logic [15:0] w;
        cs_up();
        hdr(2'b10, 8'h4C, q);
        chk("R4", "dummy before stream", q, 0);
        for (int k = 0; k < 3; k++) begin
            read16(w);
            chk("R6", "sequential word", w, exp_word(8'h4C + 8'(k)));
        end
        cs_down();
    endtask

    task automatic t_wrap();
        logic q;
        logic [15:0] w;
        cs_up();
        hdr(2'b10, 8'hFE, q);
        read16(w);
        chk("R7", "word FE", w, exp_word(8'hFE));
        read16(w);
        chk("R7", "word FF", w, exp_word(8'hFF));
        read16(w);
        chk("R7", "wrapped word 00", w, exp_word(8'h00));
        cs_down();
    endtask

    task automatic t_start_zeros();
        logic q;
        logic [15:0] w;
        cs_up();
        for (int k = 0; k < 3; k++) begin
            sbit(1'b0, q);
            chk("R3", "quiet before start", q, 0);
        end
        hdr(2'b10, 8'h81, q);
        read16(w);
        chk("R3", "word after leading zeros", w, exp_word(8'h81));
        cs_down();
    endtask

    task automatic t_preg(input logic [7:0] r, input logic f);
        logic q;
        logic [8:0] got;
        int p0;
        p0 = n_pulse;
        pre_en = 1'b1;
        prot_reg = r;
        prot_flag = f;
        cs_up();
        hdr(2'b10, 8'h00, q);
        chk("R8", "protect read dummy", q, 0);
        for (int i = 8; i >= 0; i--) begin
            sbit(1'b0, q);
            got[i] = q;
        end
        chk("R8", "register and flag", got, {r, f});
        for (int k = 0; k < 4; k++) begin
            sbit(1'b1, q);
            chk("R8", "low after flag", q, 0);
        end
        chk("R8", "no forward on protect read", n_pulse, p0);
        cs_down();
        pre_en = 1'b0;
    endtask

    task automatic t_forward(input logic [1:0] op, input logic [7:0] a, input logic p);
        logic q;
        logic any;
        int p0;
        p0 = n_pulse;
        pre_en = p;
        cs_up();
        hdr(op, a, q);
        repeat (2) @(negedge clk);
        chk("R9", "one pulse", n_pulse, p0 + 1);
        chk("R9", "forwarded opcode", last_op, op);
        chk("R9", "forwarded address", last_addr, a);
        any = 1'b0;
        for (int k = 0; k < 16; k++) begin
            sbit(1'b1, q);
            any = any | q;
        end
        chk("R9", "dout low during data", any, 0);
        chk("R9", "still one pulse", n_pulse, p0 + 1);
        cs_down();
        pre_en = 1'b0;
    endtask

    task automatic t_lockout();
        logic q;
        logic any;
        logic [15:0] w;
        int p0;
        p0 = n_pulse;
        sck = 1'b1;
        repeat (3) @(negedge clk);
        cs = 1'b1;
        repeat (3) @(negedge clk);
        sck = 1'b0;
        repeat (3) @(negedge clk);
        hdr(2'b01, 8'h55, q);
        any = q;
        for (int k = 0; k < 16; k++) begin
            sbit(1'b1, q);
            any = any | q;
        end
        chk("R2", "dout low in lockout", any, 0);
        chk("R2", "no forward in lockout", n_pulse, p0);
        cs_down();
        cs_up();
        hdr(2'b10, 8'h07, q);
        read16(w);
        chk("R2", "read after lockout", w, exp_word(8'h07));
        cs_down();
    endtask

    task automatic t_abort();
        logic q;
        logic [15:0] w;
        cs_up();
        hdr(2'b10, 8'h20, q);
        for (int k = 0; k < 5; k++) sbit(1'b0, q);
        cs_down();
        chk("R10", "oe low after abort", dout_oe, 0);
        chk("R10", "dout low after abort", dout, 0);
        cs_up();
        hdr(2'b10, 8'h21, q);
        chk("R10", "dummy after abort", q, 0);
        read16(w);
        chk("R10", "word after abort", w, exp_word(8'h21));
        cs_down();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_single_read();
        t_seq_read();
        t_wrap();
        t_start_zeros();
        t_preg(8'h9C, 1'b1);
        t_preg(8'h35, 1'b0);
        t_forward(2'b01, 8'h33, 1'b0);
        t_forward(2'b11, 8'hFF, 1'b1);
        t_forward(2'b00, 8'hC0, 1'b0);
        t_lockout();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule